// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Shadowed Selection

This block is the digital control for a 10-bit successive-approximation converter. It runs from a system clock qualified by a tick enable. The tick fires twice per ADC clock period, so half-clock timing points fall on the falling half of the ADC clock. A conversion can be requested in three ways: a start write, an external trigger while auto-trigger is enabled, or free-running operation. Free-running operation launches the next conversion in the same tick that completes the previous one.

The channel and reference codes are not written straight into the active selection. The CPU writes them into a temporary register. The active selection copies that register on every tick while it is unlocked. The copy is locked from the start of a conversion until its last ADC clock, so the sampling window never sees a change. A sample-and-hold strobe, a trial code for the DAC, a sticky completion flag and the 10-bit result are produced from a single comparator bit that the DAC/comparator path returns.

Top module: `adc_seq_top`

## Requirements
- R1: `sel_wr` loads `sel_chan_in`/`sel_ref_in` into a temporary register. While no conversion runs, `act_chan`/`act_ref` copy that register on every `adc_tick`.
- R2: A start write or an accepted trigger is held pending. The conversion begins on the next rising-phase tick (the 1st, 3rd, 5th ... tick after reset). `busy` reads 1 from the cycle after the request until the conversion completes.
- R3: The first conversion after reset or after `conv_en` is raised lasts 50 ticks (25 ADC clocks). `sh_strobe` pulses once, for one cycle, after the tick that is 27 ticks past the start.
- R4: A conversion started by a start write that is not the first lasts 26 ticks, and the sample strobe follows tick 3.
- R5: A conversion started by `trig_in` with `auto_en` = 1 lasts 27 ticks, and the sample strobe follows tick 4.
- R6: Once a conversion begins, `act_chan`/`act_ref` are frozen. Copying resumes in the last two ticks (last ADC clock) before completion.
- R7: Ten trial steps run MSB first, one every second tick, starting two ticks after the sample point. `sar_code` is the kept bits ORed with the bit under trial. A step keeps its bit when `cmp_in` = 1. `result` takes the kept bits at completion.
- R8: `done_flag` is set on the completion tick and stays set until `flag_clr` is pulsed. A completion in the same cycle as `flag_clr` leaves it set.
- R9: With `free_run` = 1, a new conversion of the R4 kind starts on the completion tick itself. `busy` stays 1 across the boundary.
- R10: A start write or trigger arriving while a conversion is running or pending is dropped. `trig_in` with `auto_en` = 0 has no effect.
- R11: Dropping `conv_en` aborts any conversion or pending request. The next conversion after it is raised again is of the first kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_tick | input | 1 | Half-ADC-clock enable |
| conv_en | input | 1 | Converter enable |
| sel_wr | input | 1 | Write strobe for the temporary selection |
| sel_chan_in | input | 6 | Channel code to write |
| sel_ref_in | input | 3 | Reference code to write |
| start_wr | input | 1 | Start command write |
| auto_en | input | 1 | Accept external triggers |
| trig_in | input | 1 | External trigger pulse |
| free_run | input | 1 | Restart at each completion |
| flag_clr | input | 1 | Write-one-to-clear for the completion flag |
| cmp_in | input | 1 | Comparator: 1 when input >= trial code |
| act_chan | output | 6 | Active channel code |
| act_ref | output | 3 | Active reference code |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| sar_code | output | 10 | Trial code to the DAC |
| result | output | 10 | Last conversion result |
| done_flag | output | 1 | Sticky completion flag |
| busy | output | 1 | Start bit read-back |

## Verification
The bench changes the selection in the middle of a conversion. A design that fails to lock would move `act_chan` inside the sampling window, and one that never unlocks would keep the old code after completion. All three conversion kinds run, with input codes at zero, full scale and alternating patterns. A design with a wrong kind table would misplace the sample strobe or the completion. A trial sequence run in the wrong bit order would give a wrong result. Free-running back-to-back conversions, triggers that are ignored, and aborts followed by re-enable are also covered. A design that restarts late, honours a stray trigger or forgets the first-conversion kind would diverge from the clock-by-clock model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {K_FIRST = 2'd0, K_NORM = 2'd1, K_AUTO = 2'd2} conv_kind_e;

  localparam int FIRST_LEN_H = 50;
  localparam int FIRST_SH_H  = 27;
  localparam int NORM_LEN_H  = 26;
  localparam int NORM_SH_H   = 3;
  localparam int AUTO_LEN_H  = 27;
  localparam int AUTO_SH_H   = 4;

  function automatic int len_h(conv_kind_e k);
    case (k)
      K_FIRST: return FIRST_LEN_H;
      K_AUTO:  return AUTO_LEN_H;
      default: return NORM_LEN_H;
    endcase
  endfunction

  function automatic int sh_h(conv_kind_e k);
    case (k)
      K_FIRST: return FIRST_SH_H;
      K_AUTO:  return AUTO_SH_H;
      default: return NORM_SH_H;
    endcase
  endfunction
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int RES = 10,
  parameter int CW  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic start_wr,
  input  logic auto_en,
  input  logic trig,
  input  logic free_run,
  output logic busy,
  output logic lock,
  output logic start_ev,
  output logic sh_ev,
  output logic step_ev,
  output logic done_ev
);
  logic       phase_q, phase_d;
  logic       act_q, act_d;
  logic       pend_q, pend_d;
  logic       pauto_q, pauto_d;
  logic       first_q, first_d;
  logic [CW-1:0] cnt_q, cnt_d;
  conv_kind_e kind_q, kind_d;

  int  len, shp, off;
  logic run, launch, restart;

  always_comb begin
    len     = len_h(kind_q);
    shp     = sh_h(kind_q);
    off     = int'(cnt_q) - shp;
    run     = act_q & enable & tick;
    done_ev = run & (int'(cnt_q) == len - 1);
    sh_ev   = run & (int'(cnt_q) == shp);
    step_ev = run & (off >= 2) & (off <= 2 * RES) & (off % 2 == 0);
    launch  = tick & ~phase_q & pend_q & ~act_q & enable;
    restart = done_ev & free_run;
    start_ev = launch | restart;
    lock    = act_q & (int'(cnt_q) < len - 2);
    busy    = act_q | pend_q;
  end

  always_comb begin
    phase_d = tick ? ~phase_q : phase_q;
    act_d   = act_q;
    pend_d  = pend_q;
    pauto_d = pauto_q;
    first_d = first_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    if (!enable) begin
      act_d   = 1'b0;
      pend_d  = 1'b0;
      first_d = 1'b1;
      cnt_d   = '0;
    end else begin
      if (launch) begin
        act_d   = 1'b1;
        cnt_d   = '0;
        kind_d  = first_q ? K_FIRST : (pauto_q ? K_AUTO : K_NORM);
        first_d = 1'b0;
        pend_d  = 1'b0;
      end else if (run) begin
        if (done_ev) begin
          cnt_d = '0;
          if (restart) kind_d = K_NORM;
          else         act_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (!act_q && !pend_q) begin
        if (start_wr) begin
          pend_d  = 1'b1;
          pauto_d = 1'b0;
        end else if (auto_en && trig) begin
          pend_d  = 1'b1;
          pauto_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      pauto_q <= 1'b0;
      first_q <= 1'b1;
      cnt_q   <= '0;
      kind_q  <= K_NORM;
    end else begin
      phase_q <= phase_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      pauto_q <= pauto_d;
      first_q <= first_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
    end
  end

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && enable && !busy) |=> busy);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (int'(cnt_q) < len));
endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
  parameter int CH_W  = 6,
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             lock,
  input  logic             wr,
  input  logic [CH_W-1:0]  chan_in,
  input  logic [REF_W-1:0] ref_in,
  output logic [CH_W-1:0]  act_chan,
  output logic [REF_W-1:0] act_ref
);
  logic [CH_W-1:0]  tmp_ch_q, tmp_ch_d, act_ch_d;
  logic [REF_W-1:0] tmp_rf_q, tmp_rf_d, act_rf_d;
  logic             copy_en;

  always_comb begin
    copy_en  = tick & ~lock;
    tmp_ch_d = wr ? chan_in : tmp_ch_q;
    tmp_rf_d = wr ? ref_in  : tmp_rf_q;
    act_ch_d = copy_en ? tmp_ch_q : act_chan;
    act_rf_d = copy_en ? tmp_rf_q : act_ref;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_ch_q <= '0;
      tmp_rf_q <= '0;
      act_chan <= '0;
      act_ref  <= '0;
    end else begin
      tmp_ch_q <= tmp_ch_d;
      tmp_rf_q <= tmp_rf_d;
      act_chan <= act_ch_d;
      act_ref  <= act_rf_d;
    end
  end

  // R6
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(act_chan) && $stable(act_ref)));
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_ev,
  input  logic           step_ev,
  input  logic           done_ev,
  input  logic           cmp_in,
  output logic [RES-1:0] sar_code,
  output logic [RES-1:0] result
);
  localparam int IW = $clog2(RES + 1);

  logic [RES-1:0] acc_q, acc_d, mask, res_d;
  logic [IW-1:0]  idx_q, idx_d;

  always_comb begin
    mask = '0;
    for (int i = 0; i < RES; i++)
      if (int'(idx_q) == i) mask[RES-1-i] = 1'b1;
    sar_code = acc_q | mask;
    acc_d = acc_q;
    idx_d = idx_q;
    res_d = done_ev ? acc_q : result;
    if (start_ev) begin
      acc_d = '0;
      idx_d = '0;
    end else if (step_ev) begin
      if (cmp_in) acc_d = acc_q | mask;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      idx_q  <= IW'(RES);
      result <= '0;
    end else begin
      acc_q  <= acc_d;
      idx_q  <= idx_d;
      result <= res_d;
    end
  end

  // R7
  acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> ((acc_q & $past(acc_q)) == $past(acc_q)));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int RES   = 10,
  parameter int CH_W  = 6,
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_tick,
  input  logic             conv_en,
  input  logic             sel_wr,
  input  logic [CH_W-1:0]  sel_chan_in,
  input  logic [REF_W-1:0] sel_ref_in,
  input  logic             start_wr,
  input  logic             auto_en,
  input  logic             trig_in,
  input  logic             free_run,
  input  logic             flag_clr,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  act_chan,
  output logic [REF_W-1:0] act_ref,
  output logic             sh_strobe,
  output logic [RES-1:0]   sar_code,
  output logic [RES-1:0]   result,
  output logic             done_flag,
  output logic             busy
);
  localparam int CW = $clog2(adc_seq_pkg::FIRST_LEN_H + 1);

  logic lock, start_ev, sh_ev, step_ev, done_ev;
  logic done_d;

  adc_conv_timer #(.RES(RES), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(adc_tick), .enable(conv_en),
    .start_wr(start_wr), .auto_en(auto_en), .trig(trig_in), .free_run(free_run),
    .busy(busy), .lock(lock), .start_ev(start_ev), .sh_ev(sh_ev),
    .step_ev(step_ev), .done_ev(done_ev)
  );

  adc_sel_shadow #(.CH_W(CH_W), .REF_W(REF_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .tick(adc_tick), .lock(lock), .wr(sel_wr),
    .chan_in(sel_chan_in), .ref_in(sel_ref_in),
    .act_chan(act_chan), .act_ref(act_ref)
  );

  adc_sar_reg #(.RES(RES)) u_sar (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .step_ev(step_ev),
    .done_ev(done_ev), .cmp_in(cmp_in), .sar_code(sar_code), .result(result)
  );

  always_comb begin
    done_d = done_flag;
    if (done_ev)       done_d = 1'b1;
    else if (flag_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      sh_strobe <= 1'b0;
    end else begin
      done_flag <= done_d;
      sh_strobe <= sh_ev;
    end
  end

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> done_flag);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_tick = 1'b0;
  logic conv_en = 1'b1;
  logic sel_wr = 1'b0;
  logic [5:0] sel_chan_in = '0;
  logic [2:0] sel_ref_in = '0;
  logic start_wr = 1'b0, auto_en = 1'b0, trig_in = 1'b0, free_run = 1'b0, flag_clr = 1'b0;
  logic cmp_in;
  logic [5:0] act_chan;
  logic [2:0] act_ref;
  logic sh_strobe, done_flag, busy;
  logic [9:0] sar_code, result;
  logic [9:0] vin = '0;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_in = (vin >= sar_code);

  adc_seq_top dut (
    .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .conv_en(conv_en),
    .sel_wr(sel_wr), .sel_chan_in(sel_chan_in), .sel_ref_in(sel_ref_in),
    .start_wr(start_wr), .auto_en(auto_en), .trig_in(trig_in), .free_run(free_run),
    .flag_clr(flag_clr), .cmp_in(cmp_in), .act_chan(act_chan), .act_ref(act_ref),
    .sh_strobe(sh_strobe), .sar_code(sar_code), .result(result),
    .done_flag(done_flag), .busy(busy)
  );

  always @(negedge clk) adc_tick <= rst_n ? ~adc_tick : 1'b0;

  // behavioural reference model
  int m_phase, m_act, m_pend, m_pauto, m_first, m_cnt, m_kind;
  int m_tch, m_tref, m_ch, m_ref, m_acc, m_idx, m_res, m_done, m_sh;
  int e_len, e_sh, e_off, e_trial;
  bit e_run, e_doneev, e_shev, e_step, e_launch, e_restart, e_lock;

  function automatic int kind_len(int k);
    return (k == 0) ? 50 : (k == 1) ? 26 : 27;
  endfunction
  function automatic int kind_sh(int k);
    return (k == 0) ? 27 : (k == 1) ? 3 : 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_act = 0; m_pend = 0; m_pauto = 0; m_first = 1; m_cnt = 0; m_kind = 1;
      m_tch = 0; m_tref = 0; m_ch = 0; m_ref = 0; m_acc = 0; m_idx = 10; m_res = 0;
      m_done = 0; m_sh = 0;
    end else begin
      e_len = kind_len(m_kind);
      e_sh  = kind_sh(m_kind);
      e_run = (m_act != 0) && conv_en && adc_tick;
      e_doneev = e_run && (m_cnt == e_len - 1);
      e_shev = e_run && (m_cnt == e_sh);
      e_off = m_cnt - e_sh;
      e_step = e_run && e_off >= 2 && e_off <= 20 && (e_off % 2 == 0);
      e_launch = adc_tick && m_phase == 0 && m_pend != 0 && m_act == 0 && conv_en;
      e_restart = e_doneev && free_run;
      e_lock = (m_act != 0) && (m_cnt < e_len - 2);
      if (adc_tick && !e_lock) begin m_ch = m_tch; m_ref = m_tref; end
      if (sel_wr) begin m_tch = sel_chan_in; m_tref = sel_ref_in; end
      if (e_doneev) m_res = m_acc;
      if (e_launch || e_restart) begin m_acc = 0; m_idx = 0; end
      else if (e_step) begin
        e_trial = m_acc | (1 << (9 - m_idx));
        if (vin >= e_trial) m_acc = e_trial;
        m_idx++;
      end
      m_sh = e_shev;
      if (e_doneev) m_done = 1; else if (flag_clr) m_done = 0;
      if (!conv_en) begin m_act = 0; m_pend = 0; m_first = 1; m_cnt = 0; end
      else begin
        if (e_launch) begin
          m_act = 1; m_cnt = 0; m_pend = 0;
          m_kind = m_first ? 0 : (m_pauto ? 2 : 1);
          m_first = 0;
        end else if (e_run) begin
          if (e_doneev) begin
            m_cnt = 0;
            if (e_restart) m_kind = 1; else m_act = 0;
          end else m_cnt++;
        end
        if (!e_launch && !e_run && m_act == 0 && m_pend == 0) begin
          if (start_wr) begin m_pend = 1; m_pauto = 0; end
          else if (auto_en && trig_in) begin m_pend = 1; m_pauto = 1; end
        end else if (m_act == 0 && m_pend == 0 && !e_launch) begin
          if (start_wr) begin m_pend = 1; m_pauto = 0; end
          else if (auto_en && trig_in) begin m_pend = 1; m_pauto = 1; end
        end
      end
      if (adc_tick) m_phase = 1 - m_phase;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_code();
    return (m_idx < 10) ? (m_acc | (1 << (9 - m_idx))) : m_acc;
  endfunction

  always @(negedge clk) if (rst_n) begin
    chk(act_chan == m_ch[5:0] && act_ref == m_ref[2:0], "R6 selection", {act_ref, act_chan}, {m_ref[2:0], m_ch[5:0]});
    chk(sh_strobe == m_sh[0], (m_kind == 0) ? "R3 strobe" : (m_kind == 1) ? "R4 strobe" : "R5 strobe", sh_strobe, m_sh);
    chk(sar_code == exp_code(), "R7 trial code", sar_code, exp_code());
    chk(result == m_res[9:0], "R7 result", result, m_res);
    chk(done_flag == m_done[0], "R8 done flag", done_flag, m_done);
    chk(busy == (m_act != 0 || m_pend != 0), "R2 busy", busy, (m_act != 0 || m_pend != 0));
  end

  task automatic pulse_start();
    start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
  endtask
  task automatic pulse_trig();
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
  endtask
  task automatic write_sel(input int ch, input int rf);
    sel_chan_in = 6'(ch); sel_ref_in = 3'(rf); sel_wr = 1'b1;
    @(negedge clk); sel_wr = 1'b0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic clear_flag();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done_flag == 0 && result == 0, "R2 reset state", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: idle tracking
    write_sel(5, 2);
    repeat (4) @(negedge clk);
    chk(act_chan == 6'd5 && act_ref == 3'd2, "R1 idle tracking", act_chan, 5);
    // R3: first conversion, selection change mid-conversion (R6)
    vin = 10'h2A5;
    pulse_start();
    repeat (10) @(negedge clk);
    write_sel(17, 6);
    repeat (6) @(negedge clk);
    chk(act_chan == 6'd5, "R6 locked during conversion", act_chan, 5);
    wait_idle();
    chk(result == 10'h2A5, "R7 first result", result, 10'h2A5);
    chk(act_chan == 6'd17, "R6 released after completion", act_chan, 17);
    clear_flag();
    chk(done_flag == 0, "R8 cleared", done_flag, 0);
    // R4: normal conversions at full scale and zero
    vin = 10'h3FF; pulse_start(); wait_idle();
    chk(result == 10'h3FF, "R4 full scale", result, 10'h3FF);
    vin = 10'h000; pulse_start(); wait_idle();
    chk(result == 10'h000, "R4 zero", result, 0);
    // R10: trigger without auto enable ignored
    pulse_trig();
    repeat (2) @(negedge clk);
    chk(busy == 0, "R10 trigger ignored", busy, 0);
    // R5: auto-triggered, with stray trigger/start while busy
    auto_en = 1'b1; vin = 10'h155;
    pulse_trig();
    repeat (8) @(negedge clk);
    pulse_trig(); pulse_start();
    wait_idle();
    chk(result == 10'h155, "R5 auto result", result, 10'h155);
    auto_en = 1'b0;
    // R9: free running
    free_run = 1'b1; vin = 10'h0F0;
    pulse_start();
    @(negedge clk);
    while (!done_flag) @(negedge clk);
    chk(busy == 1, "R9 busy across restart", busy, 1);
    clear_flag();
    vin = 10'h30F;
    while (!done_flag) @(negedge clk);
    free_run = 1'b0;
    wait_idle();
    chk(result == 10'h30F, "R9 second result", result, 10'h30F);
    clear_flag();
    // R11: abort then first-kind conversion
    vin = 10'h1C3; pulse_start();
    repeat (12) @(negedge clk);
    conv_en = 1'b0; @(negedge clk); @(negedge clk);
    chk(busy == 0 && done_flag == 0, "R11 abort", busy, 0);
    conv_en = 1'b1;
    pulse_start(); wait_idle();
    chk(result == 10'h1C3, "R11 result after re-enable", result, 10'h1C3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule